// File: doc/BRIEF.md
# Serial Two-Wire Register Slave

This block lets an external bus master read and write a small bank of byte-wide registers over a two-wire serial bus (open-drain data, master-driven clock). The clock and data lines are brought into the system clock domain through synchronizer chains. Edge logic then finds clock edges and the bus start and stop conditions, and a byte-level state machine decodes the device address, loads a register pointer, stores incoming data and shifts out read data.

The device address is picked by a strap pin between two fixed 7-bit values. A bus write always carries a pointer byte first and then any number of data bytes. A bus read returns bytes from the current pointer. A repeated start between a pointer write and a read gives a random-access read. A stop ends the access at any bit. The one exception is a stop that falls inside the same clock-high phase as the start, which the block ignores. Local logic reaches the same bank through a plain host port.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The 7-bit device address is 7'b0010000 when `addr_sel` is 0 and 7'b0010001 when it is 1; the address byte is sent MSB first with R/W in bit 0 (0 = write, 1 = read), so the byte values are 0x20/0x21 and 0x22/0x23. On a match the block pulls SDA low (`sda_oe` = 1) for the ninth clock.
- R2: When the address does not match, the block gives no acknowledge, keeps `sda_oe` at 0 and ignores every following byte until the next start condition.
- R3: In a write, the first byte after the address loads the register pointer from its low `REG_AW` bits and is acknowledged.
- R4: Each later write byte is stored at the pointer and acknowledged, and then the pointer steps by one, wrapping from the last register to register 0.
- R5: In a read, the block shifts out the register at the pointer MSB first, with each bit valid before the clock rises. The first MSB is already on SDA before the first rising edge after the address acknowledge. The pointer steps by one per byte. A master ACK (SDA low on the ninth clock) continues with the next byte, and a NACK ends the block's driving. A read with no pointer write uses the current pointer.
- R6: A repeated start restarts address decoding and keeps the pointer, so a pointer write followed by a repeated-start read returns the selected register.
- R7: A stop (SDA rising while SCL is high) at any bit position returns the block to idle with `sda_oe` = 0, and a partly received byte is not stored.
- R8: A stop that falls in the same SCL high phase as the start before it is ignored, and the transaction continues.
- R9: SDA is driven only through the pull-low enable `sda_oe`, which never changes while SCL is high.
- R10: `host_we` writes `host_wdata` to register `host_addr` on the clock edge, and `host_rdata` shows register `host_addr` combinationally.
- R11: After reset `sda_oe` is 0, the pointer is 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap selecting one of the two device addresses |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| host_we | input | 1 | Host write strobe |
| host_addr | input | REG_AW | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at `host_addr` |

## Verification
The bench builds the block with its defaults, a 16-entry bank and two synchronizer stages, and runs the bus at about 390 kHz from a 50 MHz clock. The 16-entry bank lets a pointer byte with upper bits set check truncation, and it lets a two-byte burst from register 15 check the wrap to register 0. Two-stage synchronizing keeps every response far inside a quarter bit period, so the bench can check the acknowledge and read-data bits directly. It also watches every SCL high phase to see whether `sda_oe` moves.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
    localparam logic [6:0] DEV_ADDR_BASE = 7'b0010000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_RDATA,
        ST_IGN
    } bus_st_e;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '1;
        else        stg_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= '1;
            else        stg_q[i] <= stg_q[i-1];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rb_cond.sv
module i2c_rb_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p_q, sda_p_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_s;
            sda_p_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_p_q;
        scl_fall  = ~scl_s & scl_p_q;
        start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
        stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
    end
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (b_we) mem_d[b_addr] = b_wdata;
        if (a_we) mem_d[a_addr] = a_wdata;   // bus side wins a same-cycle clash
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign a_rdata = mem_q[a_addr];
    assign b_rdata = mem_q[b_addr];
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
    parameter int REG_AW      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    import i2c_rb_pkg::*;

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    typedef struct packed {
        bus_st_e           st;
        logic              ack_ph;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [7:0]        tx;
        logic [REG_AW-1:0] ptr;
        logic              oe;
        logic              start_hi;
        logic              rw;
        logic              mack;
    } ctx_t;

    ctx_t        d, q;
    logic        scl_s, sda_s;
    logic        scl_rise, scl_fall, start_det, stop_det;
    logic        bus_we;
    logic [7:0]  rd_byte;
    logic [6:0]  my_addr;

    i2c_rb_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout ({scl_s, sda_s})
    );

    i2c_rb_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_rb_regs #(.AW(REG_AW), .DW(8)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_we   (bus_we),
        .a_addr (q.ptr),
        .a_wdata(q.sh),
        .a_rdata(rd_byte),
        .b_we   (host_we),
        .b_addr (host_addr),
        .b_wdata(host_wdata),
        .b_rdata(host_rdata)
    );

    assign my_addr = DEV_ADDR_BASE | {6'd0, addr_sel};

    always_comb begin
        d      = q;
        bus_we = 1'b0;
        if (start_det) begin
            d.st       = ST_ADDR;
            d.ack_ph   = 1'b0;
            d.cnt      = '0;
            d.oe       = 1'b0;
            d.start_hi = 1'b1;
        end else if (stop_det && !q.start_hi) begin
            d.st     = ST_IDLE;
            d.ack_ph = 1'b0;
            d.cnt    = '0;
            d.oe     = 1'b0;
        end else if (q.st != ST_IDLE && q.st != ST_IGN) begin
            if (scl_fall) d.start_hi = 1'b0;
            if (!q.ack_ph) begin
                if (scl_rise) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                end
                if (scl_fall && q.cnt == BITS_PER_BYTE) begin
                    d.ack_ph = 1'b1;
                    d.cnt    = '0;
                    case (q.st)
                        ST_ADDR: begin
                            if (q.sh[7:1] == my_addr) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                            end else begin
                                d.st = ST_IGN;
                                d.oe = 1'b0;
                            end
                        end
                        ST_PTR: begin
                            d.ptr = q.sh[REG_AW-1:0];
                            d.oe  = 1'b1;
                        end
                        ST_WDATA: begin
                            bus_we = 1'b1;
                            d.ptr  = q.ptr + REG_AW'(1);
                            d.oe   = 1'b1;
                        end
                        ST_RDATA: begin
                            d.ptr = q.ptr + REG_AW'(1);
                            d.oe  = 1'b0;
                        end
                        default: d.oe = 1'b0;
                    endcase
                end else if (scl_fall && q.st == ST_RDATA && q.cnt != '0) begin
                    d.tx = {q.tx[6:0], 1'b0};
                    d.oe = ~q.tx[6];
                end
            end else begin
                if (scl_rise) d.mack = ~sda_s;
                if (scl_fall) begin
                    d.ack_ph = 1'b0;
                    d.cnt    = '0;
                    d.oe     = 1'b0;
                    case (q.st)
                        ST_ADDR: begin
                            if (q.rw) begin
                                d.st = ST_RDATA;
                                d.tx = rd_byte;
                                d.oe = ~rd_byte[7];
                            end else begin
                                d.st = ST_PTR;
                            end
                        end
                        ST_PTR:   d.st = ST_WDATA;
                        ST_WDATA: d.st = ST_WDATA;
                        ST_RDATA: begin
                            if (q.mack) begin
                                d.tx = rd_byte;
                                d.oe = ~rd_byte[7];
                            end else begin
                                d.st = ST_IGN;
                            end
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;

    // R2: an unmatched address leaves the line untouched
    p_silent_when_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGN) |-> !sda_oe);

    // R4: every stored byte advances the pointer by one
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (q.ptr == $past(q.ptr) + REG_AW'(1)));

    // R7: an accepted stop lands in idle with the line released
    p_stop_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !q.start_hi && !start_det) |=> (q.st == ST_IDLE && !sda_oe));

    // R9: the pull-low enable holds through each SCL high phase
    p_oe_stable_scl_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !start_det && !stop_det) |-> $stable(sda_oe));

    // R3: the bit counter never passes one byte
    p_bitcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= BITS_PER_BYTE);
endmodule

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;
    localparam int AW = 4;
    localparam int Q  = 32;           // clocks per quarter bit
    localparam int NREG = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic sda_line;

    int cmp_cnt = 0;
    int bad_cnt = 0;
    logic [7:0] model [NREG];
    int mptr = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = !(m_low || sda_oe);

    i2c_regbank_slave #(.REG_AW(AW), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_sel  (addr_sel),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .host_we   (host_we),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    task automatic report_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, bad_cnt);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        cmp_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // R9 monitor: once SCL has been high long enough to pass the synchronizer,
    // the pull-low enable must not move until SCL falls
    int   hi_cnt = 0;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl) begin
            hi_cnt <= hi_cnt + 1;
            if (hi_cnt >= 6 && sda_oe !== oe_prev) begin
                cmp_cnt++;
                bad_cnt++;
                $display("FAIL R9: actual %0b expected %0b", sda_oe, oe_prev);
            end else if (hi_cnt == 6) begin
                cmp_cnt++;
            end
        end else begin
            hi_cnt <= 0;
        end
        oe_prev <= sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        cmp_cnt++;
        bad_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_and_end();
    end

    // ---- bus master tasks ----
    task automatic bus_start();
        m_low = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        m_low = 1'b1; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        m_low = 1'b0; wq(Q);
    endtask

    task automatic bit_out(input logic b);
        m_low = !b; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output logic b);
        m_low = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        b = sda_line; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(b);
        ack = !b;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(!mack);
    endtask

    task automatic host_chk(input string tag, input int a);
        host_addr = AW'(a);
        wq(1);
        chk(tag, host_rdata, model[a]);
    endtask

    initial begin
        logic ack;
        logic [7:0] rv;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        wq(5);
        // R11: reset state
        chk("R11 sda_oe in reset", sda_oe, 1'b0);
        rst_n = 1'b1;
        wq(4);
        chk("R11 sda_oe after reset", sda_oe, 1'b0);
        host_chk("R11 reg0 cleared", 0);
        host_chk("R11 reg9 cleared", 9);

        // R10: host port fill and readback
        for (int i = 0; i < NREG; i++) begin
            host_we = 1'b1; host_addr = AW'(i); host_wdata = 8'hC0 + 8'(i);
            model[i] = 8'hC0 + 8'(i);
            wq(1);
        end
        host_we = 1'b0;
        host_chk("R10 host readback reg2", 2);
        host_chk("R10 host readback reg14", 14);

        // R1/R3/R4: write with strap low
        bus_start();
        write_byte(8'h20, ack); chk("R1 address 0x20 acked", ack, 1'b1);
        write_byte(8'h03, ack); chk("R3 pointer byte acked", ack, 1'b1);
        mptr = 3;
        write_byte(8'hA5, ack); chk("R4 data acked", ack, 1'b1);
        model[mptr] = 8'hA5; mptr = (mptr + 1) % NREG;
        write_byte(8'h5A, ack); chk("R4 second data acked", ack, 1'b1);
        model[mptr] = 8'h5A; mptr = (mptr + 1) % NREG;
        bus_stop();
        wq(Q);
        host_chk("R4 reg3 stored", 3);
        host_chk("R4 reg4 stored", 4);

        // R2: wrong address ignored
        bus_start();
        write_byte(8'h22, ack); chk("R2 address 0x22 not acked", ack, 1'b0);
        write_byte(8'h01, ack); chk("R2 byte after mismatch not acked", ack, 1'b0);
        write_byte(8'hFF, ack); chk("R2 second byte not acked", ack, 1'b0);
        bus_stop();
        wq(Q);
        chk("R2 line released", sda_oe, 1'b0);
        host_chk("R2 reg1 untouched", 1);
        host_chk("R2 reg5 untouched", 5);

        // R6/R5: pointer write, repeated start, burst read
        bus_start();
        write_byte(8'h20, ack); chk("R6 address acked", ack, 1'b1);
        write_byte(8'h03, ack); chk("R6 pointer acked", ack, 1'b1);
        mptr = 3;
        bus_start();
        write_byte(8'h21, ack); chk("R6 read address acked", ack, 1'b1);
        read_byte(rv, 1'b1); chk("R5 read byte 0", rv, model[mptr]); mptr = (mptr + 1) % NREG;
        read_byte(rv, 1'b1); chk("R5 read byte 1", rv, model[mptr]); mptr = (mptr + 1) % NREG;
        read_byte(rv, 1'b0); chk("R5 read byte 2", rv, model[mptr]); mptr = (mptr + 1) % NREG;
        wq(Q);
        chk("R5 released after nack", sda_oe, 1'b0);
        bus_stop();

        // R5: read without pointer write continues from current pointer
        bus_start();
        write_byte(8'h21, ack); chk("R5 direct read address acked", ack, 1'b1);
        read_byte(rv, 1'b0); chk("R5 read at current pointer", rv, model[mptr]);
        mptr = (mptr + 1) % NREG;
        bus_stop();

        // R1/R2/R4: strap high, other address, wrap
        addr_sel = 1'b1;
        wq(4);
        bus_start();
        write_byte(8'h20, ack); chk("R1 0x20 rejected with strap high", ack, 1'b0);
        bus_stop();
        bus_start();
        write_byte(8'h22, ack); chk("R1 address 0x22 acked", ack, 1'b1);
        write_byte(8'h1F, ack); chk("R3 pointer truncated acked", ack, 1'b1);
        mptr = 8'h1F % NREG;
        write_byte(8'h11, ack); model[mptr] = 8'h11; mptr = (mptr + 1) % NREG;
        write_byte(8'h22, ack); model[mptr] = 8'h22; mptr = (mptr + 1) % NREG;
        chk("R4 wrap byte acked", ack, 1'b1);
        bus_stop();
        wq(Q);
        host_chk("R4 reg15 written", 15);
        host_chk("R4 wrap to reg0", 0);
        addr_sel = 1'b0;
        wq(4);

        // R7: stop inside address, then stop inside data
        bus_start();
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        wq(Q);
        chk("R7 idle after stop in address", sda_oe, 1'b0);
        bus_start();
        write_byte(8'h20, ack); chk("R7 new transaction acked", ack, 1'b1);
        write_byte(8'h08, ack); mptr = 8;
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
        bus_stop();
        wq(Q);
        chk("R7 released after stop in data", sda_oe, 1'b0);
        host_chk("R7 partial byte not stored", 8);

        // R8: stop in the same high phase as the start is ignored
        m_low = 1'b0; scl = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        m_low = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
        write_byte(8'h20, ack); chk("R8 address acked after ignored stop", ack, 1'b1);
        write_byte(8'h09, ack); mptr = 9;
        write_byte(8'h77, ack); chk("R8 data acked", ack, 1'b1);
        model[9] = 8'h77; mptr = 10;
        bus_stop();
        wq(Q);
        host_chk("R8 data stored", 9);

        wq(Q);
        report_and_end();
    end
endmodule